// File: doc/BRIEF.md
# Banked Polyphase Coefficient Store

This block holds the coefficient tables of a two-dimensional polyphase scaler. It keeps one memory for the vertical filter and one for the horizontal filter. Each memory is split into `NUM_BANKS` banks. The vertical memory stores one coefficient per word, and its depth is banks × vertical phases × vertical taps. The horizontal memory stores every horizontal tap of one phase in a single word, and its depth is banks × horizontal phases. The phase counts are powers of two, so a phase index is a plain bit field.

Software reaches the block through a small register window. It picks a write bank, points an index register at a phase and tap, and writes coefficient data. Separately, it picks a pending read bank. The active read bank, which is the one the filter datapath uses, takes the pending value only on a start-of-frame pulse. Software can therefore fill the idle bank while a frame runs, then change banks cleanly at the frame boundary. With one bank, writes reach the datapath at once. When the shared option is set, vertical lookups read the horizontal memory, and vertical coefficient writes are dropped.

Horizontal loads pass through a staging register, one tap per write. A small state machine (states EMPTY, PARTIAL, COMMIT) writes the full word into memory in the cycle after the last tap of a phase is written. Its transitions are as follows. A last-tap write from any state leads to COMMIT. Any other horizontal tap write leads to PARTIAL. With no write, PARTIAL stays in PARTIAL, COMMIT returns to EMPTY, and EMPTY stays in EMPTY.

Top module: `coef_store`

## Requirements
- R1: While reset is held, the write bank, pending read bank and active read bank are all 0, and both coefficient outputs are zero.
- R2: A vertical lookup presented on `v_phase`/`v_tap` gives, on `v_coef` one clock later, the coefficient stored at that phase and tap of the active read bank.
- R3: A horizontal lookup presented on `h_phase` gives, on `h_coefs` one clock later, every tap of that phase in the active read bank. Tap t is in bits [t*COEF_W +: COEF_W].
- R4: The register map has four entries. Address 0 is the write bank. Address 1 is the pending read bank. Address 2 is the index: tap in bits [7:0], phase in the low bits of [15:8], and bit 16 set to 1 for horizontal, 0 for vertical. Address 3 writes data bits [COEF_W-1:0] to the indexed location of the current write bank.
- R5: A pending read-bank value reaches the datapath only through a `sof` pulse. A lookup issued in the same cycle as `sof` still uses the old bank, and the next lookup uses the new one.
- R6: When `sof` and a write to the pending read-bank register fall in the same cycle, the active bank takes the pending value from before that write. The new value waits for the following `sof`.
- R7: A write of a bank value at or above `NUM_BANKS` to address 0 or address 1 is ignored, and the earlier value is kept.
- R8: A vertical coefficient write can be read back from the next cycle on. A vertical write whose tap is at or above `V_TAPS` changes nothing.
- R9: Horizontal tap writes are staged. The memory word changes only after the last tap (`H_TAPS-1`) of a phase is written, and it then holds all staged taps in the bank that was selected for writing at that moment.
- R10: With one bank configured, coefficient writes reach the datapath without any `sof` pulse.
- R11: In shared mode, a vertical lookup returns tap `v_tap` of the horizontal word for phase `v_phase`, and vertical coefficient writes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| sof | input | 1 | Start-of-frame pulse; loads the pending read bank into the active read bank |
| v_phase | input | VPH_W | Vertical lookup phase |
| v_tap | input | VT_W | Vertical lookup tap |
| h_phase | input | HPH_W | Horizontal lookup phase |
| v_coef | output | COEF_W | Vertical coefficient, one cycle after the lookup |
| h_coefs | output | COEF_W*H_TAPS | All horizontal taps of the looked-up phase, one cycle after the lookup |

## Verification
The start-of-frame bank load and a software write to the pending read-bank register can fall in the same clock edge. The bench drives both on one edge with a new value that differs from the pending one. It then judges, through the coefficients returned, that the old pending bank became active and that the new value only appears after a further pulse. A second overlap comes from issuing a lookup on the very edge that swaps banks. That result must come from the old bank, and the lookup right after it from the new one.

// File: rtl/coef_pkg.sv
package coef_pkg;

    localparam logic [1:0] REG_WBANK = 2'd0;
    localparam logic [1:0] REG_RBANK = 2'd1;
    localparam logic [1:0] REG_INDEX = 2'd2;
    localparam logic [1:0] REG_DATA  = 2'd3;

    localparam int IDX_PHASE_LSB = 8;
    localparam int IDX_HORIZ_BIT = 16;

    typedef enum logic [1:0] {
        HL_EMPTY,
        HL_PARTIAL,
        HL_COMMIT
    } hload_state_e;

    function automatic int width_of(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/coef_regs.sv
module coef_regs import coef_pkg::*; #(
    parameter int NUM_BANKS = 2,
    parameter int V_TAPS    = 4,
    parameter int H_TAPS    = 8,
    parameter int COEF_W    = 12,
    parameter bit SHARE     = 1'b0,
    parameter int BANK_W    = 1,
    parameter int TW        = 3,
    parameter int IPW       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              sof,
    output logic [BANK_W-1:0] wbank,
    output logic [BANK_W-1:0] pending_bank,
    output logic [BANK_W-1:0] active_bank,
    output logic              v_we,
    output logic              h_we,
    output logic              h_last,
    output logic [TW-1:0]     w_tap,
    output logic [IPW-1:0]    w_phase,
    output logic [COEF_W-1:0] w_data
);

    logic [7:0]     idx_tap;
    logic [IPW-1:0] idx_phase;
    logic           idx_horiz;
    logic           bank_ok;
    logic           data_hit;

    assign bank_ok = (reg_wdata < 32'(NUM_BANKS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbank        <= '0;
            pending_bank <= '0;
            active_bank  <= '0;
            idx_tap      <= '0;
            idx_phase    <= '0;
            idx_horiz    <= 1'b0;
        end else begin
            if (sof) begin
                active_bank <= pending_bank;
            end
            if (reg_wr) begin
                case (reg_addr)
                    REG_WBANK: if (bank_ok) wbank <= BANK_W'(reg_wdata);
                    REG_RBANK: if (bank_ok) pending_bank <= BANK_W'(reg_wdata);
                    REG_INDEX: begin
                        idx_tap   <= reg_wdata[7:0];
                        idx_phase <= reg_wdata[IDX_PHASE_LSB +: IPW];
                        idx_horiz <= reg_wdata[IDX_HORIZ_BIT];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        data_hit = reg_wr && (reg_addr == REG_DATA);
        v_we     = data_hit && !idx_horiz && (32'(idx_tap) < V_TAPS) && !SHARE;
        h_we     = data_hit && idx_horiz && (32'(idx_tap) < H_TAPS);
        h_last   = h_we && (32'(idx_tap) == H_TAPS - 1);
        w_tap    = idx_tap[TW-1:0];
        w_phase  = idx_phase;
        w_data   = reg_wdata[COEF_W-1:0];
    end

endmodule

// File: rtl/coef_hload.sv
module coef_hload import coef_pkg::*; #(
    parameter int H_TAPS = 8,
    parameter int COEF_W = 12,
    parameter int BANK_W = 1,
    parameter int HPH_W  = 4,
    parameter int HT_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     h_we,
    input  logic                     h_last,
    input  logic [HT_W-1:0]          tap,
    input  logic [BANK_W-1:0]        bank,
    input  logic [HPH_W-1:0]         phase,
    input  logic [COEF_W-1:0]        data,
    output logic                     hmem_we,
    output logic [BANK_W-1:0]        commit_bank,
    output logic [HPH_W-1:0]         commit_phase,
    output logic [COEF_W*H_TAPS-1:0] commit_word
);

    localparam int WORD_W = COEF_W * H_TAPS;

    hload_state_e          state_q;
    hload_state_e          state_d;
    logic [COEF_W-1:0]     stage [H_TAPS];
    logic [WORD_W-1:0]     merged;

    // merge the tap arriving this cycle with the staged ones
    for (genvar t = 0; t < H_TAPS; t++) begin : g_merge
        assign merged[t*COEF_W +: COEF_W] =
            (h_we && (tap == HT_W'(t))) ? data : stage[t];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < H_TAPS; t++) begin
                stage[t] <= '0;
            end
            commit_word  <= '0;
            commit_bank  <= '0;
            commit_phase <= '0;
        end else begin
            if (h_we) begin
                stage[tap] <= data;
            end
            if (h_last) begin
                commit_word  <= merged;
                commit_bank  <= bank;
                commit_phase <= phase;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HL_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HL_EMPTY: begin
                if (h_last)    state_d = HL_COMMIT;
                else if (h_we) state_d = HL_PARTIAL;
            end
            HL_PARTIAL: begin
                if (h_last)    state_d = HL_COMMIT;
            end
            HL_COMMIT: begin
                if (h_last)    state_d = HL_COMMIT;
                else if (h_we) state_d = HL_PARTIAL;
                else           state_d = HL_EMPTY;
            end
            default:           state_d = HL_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        hmem_we = (state_q == HL_COMMIT);
    end

endmodule

// File: rtl/coef_banks.sv
module coef_banks import coef_pkg::*; #(
    parameter int NUM_BANKS = 2,
    parameter int V_PHASES  = 16,
    parameter int V_TAPS    = 4,
    parameter int H_PHASES  = 16,
    parameter int H_TAPS    = 8,
    parameter int COEF_W    = 12,
    parameter bit SHARE     = 1'b0,
    parameter int BANK_W    = 1,
    parameter int VPH_W     = 4,
    parameter int VT_W      = 2,
    parameter int HPH_W     = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     v_we,
    input  logic [BANK_W-1:0]        v_wbank,
    input  logic [VPH_W-1:0]         v_wphase,
    input  logic [VT_W-1:0]          v_wtap,
    input  logic [COEF_W-1:0]        v_wdata,
    input  logic                     h_we,
    input  logic [BANK_W-1:0]        h_wbank,
    input  logic [HPH_W-1:0]         h_wphase,
    input  logic [COEF_W*H_TAPS-1:0] h_wword,
    input  logic [BANK_W-1:0]        rd_bank,
    input  logic [VPH_W-1:0]         v_phase,
    input  logic [VT_W-1:0]          v_tap,
    input  logic [HPH_W-1:0]         h_phase,
    output logic [COEF_W-1:0]        v_coef,
    output logic [COEF_W*H_TAPS-1:0] h_coefs
);

    localparam int WORD_W  = COEF_W * H_TAPS;
    localparam int H_DEPTH = NUM_BANKS * H_PHASES;
    localparam int HA_W    = width_of(H_DEPTH);
    localparam int V_DEPTH = NUM_BANKS * V_PHASES * V_TAPS;
    localparam int VA_W    = width_of(V_DEPTH);

    logic [WORD_W-1:0] hmem [H_DEPTH];
    logic [HA_W-1:0]   h_waddr;
    logic [HA_W-1:0]   h_raddr;

    assign h_waddr = HA_W'(int'(h_wbank) * H_PHASES + int'(h_wphase));
    assign h_raddr = HA_W'(int'(rd_bank) * H_PHASES + int'(h_phase));

    always_ff @(posedge clk) begin
        if (h_we) begin
            hmem[h_waddr] <= h_wword;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_coefs <= '0;
        end else begin
            h_coefs <= hmem[h_raddr];
        end
    end

    if (!SHARE) begin : g_own_vert
        logic [COEF_W-1:0] vmem [V_DEPTH];
        logic [VA_W-1:0]   v_waddr;
        logic [VA_W-1:0]   v_raddr;

        assign v_waddr = VA_W'((int'(v_wbank) * V_PHASES + int'(v_wphase)) * V_TAPS
                               + int'(v_wtap));
        assign v_raddr = VA_W'((int'(rd_bank) * V_PHASES + int'(v_phase)) * V_TAPS
                               + int'(v_tap));

        always_ff @(posedge clk) begin
            if (v_we) begin
                vmem[v_waddr] <= v_wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_coef <= '0;
            end else begin
                v_coef <= vmem[v_raddr];
            end
        end
    end else begin : g_shared_vert
        logic [HA_W-1:0] sv_raddr;

        assign sv_raddr = HA_W'(int'(rd_bank) * H_PHASES + int'(v_phase));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_coef <= '0;
            end else begin
                v_coef <= COEF_W'(hmem[sv_raddr] >> (COEF_W * int'(v_tap)));
            end
        end
    end

endmodule

// File: rtl/coef_store.sv
module coef_store import coef_pkg::*; #(
    parameter int NUM_BANKS = 2,
    parameter int V_PHASES  = 16,
    parameter int V_TAPS    = 4,
    parameter int H_PHASES  = 16,
    parameter int H_TAPS    = 8,
    parameter int COEF_W    = 12,
    parameter bit SHARE     = 1'b0,
    parameter int BANK_W    = width_of(NUM_BANKS),
    parameter int VPH_W     = width_of(V_PHASES),
    parameter int VT_W      = width_of(V_TAPS),
    parameter int HPH_W     = width_of(H_PHASES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic [1:0]               reg_addr,
    input  logic [31:0]              reg_wdata,
    input  logic                     sof,
    input  logic [VPH_W-1:0]         v_phase,
    input  logic [VT_W-1:0]          v_tap,
    input  logic [HPH_W-1:0]         h_phase,
    output logic [COEF_W-1:0]        v_coef,
    output logic [COEF_W*H_TAPS-1:0] h_coefs
);

    localparam int HT_W   = width_of(H_TAPS);
    localparam int TW     = (VT_W > HT_W) ? VT_W : HT_W;
    localparam int IPW    = (VPH_W > HPH_W) ? VPH_W : HPH_W;
    localparam int WORD_W = COEF_W * H_TAPS;

    logic [BANK_W-1:0] wbank;
    logic [BANK_W-1:0] pending_bank;
    logic [BANK_W-1:0] active_bank;
    logic              v_we;
    logic              h_we;
    logic              h_last;
    logic [TW-1:0]     w_tap;
    logic [IPW-1:0]    w_phase;
    logic [COEF_W-1:0] w_data;
    logic              hmem_we;
    logic [BANK_W-1:0] commit_bank;
    logic [HPH_W-1:0]  commit_phase;
    logic [WORD_W-1:0] commit_word;

    coef_regs #(
        .NUM_BANKS (NUM_BANKS),
        .V_TAPS    (V_TAPS),
        .H_TAPS    (H_TAPS),
        .COEF_W    (COEF_W),
        .SHARE     (SHARE),
        .BANK_W    (BANK_W),
        .TW        (TW),
        .IPW       (IPW)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .sof          (sof),
        .wbank        (wbank),
        .pending_bank (pending_bank),
        .active_bank  (active_bank),
        .v_we         (v_we),
        .h_we         (h_we),
        .h_last       (h_last),
        .w_tap        (w_tap),
        .w_phase      (w_phase),
        .w_data       (w_data)
    );

    coef_hload #(
        .H_TAPS (H_TAPS),
        .COEF_W (COEF_W),
        .BANK_W (BANK_W),
        .HPH_W  (HPH_W),
        .HT_W   (HT_W)
    ) u_hload (
        .clk          (clk),
        .rst_n        (rst_n),
        .h_we         (h_we),
        .h_last       (h_last),
        .tap          (w_tap[HT_W-1:0]),
        .bank         (wbank),
        .phase        (w_phase[HPH_W-1:0]),
        .data         (w_data),
        .hmem_we      (hmem_we),
        .commit_bank  (commit_bank),
        .commit_phase (commit_phase),
        .commit_word  (commit_word)
    );

    coef_banks #(
        .NUM_BANKS (NUM_BANKS),
        .V_PHASES  (V_PHASES),
        .V_TAPS    (V_TAPS),
        .H_PHASES  (H_PHASES),
        .H_TAPS    (H_TAPS),
        .COEF_W    (COEF_W),
        .SHARE     (SHARE),
        .BANK_W    (BANK_W),
        .VPH_W     (VPH_W),
        .VT_W      (VT_W),
        .HPH_W     (HPH_W)
    ) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .v_we     (v_we),
        .v_wbank  (wbank),
        .v_wphase (w_phase[VPH_W-1:0]),
        .v_wtap   (w_tap[VT_W-1:0]),
        .v_wdata  (w_data),
        .h_we     (hmem_we),
        .h_wbank  (commit_bank),
        .h_wphase (commit_phase),
        .h_wword  (commit_word),
        .rd_bank  (active_bank),
        .v_phase  (v_phase),
        .v_tap    (v_tap),
        .h_phase  (h_phase),
        .v_coef   (v_coef),
        .h_coefs  (h_coefs)
    );

endmodule

// File: rtl/coef_store_chk.sv
module coef_store_chk import coef_pkg::*; #(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sof,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [BANK_W-1:0] wbank,
    input logic [BANK_W-1:0] pending_bank,
    input logic [BANK_W-1:0] active_bank,
    input logic              h_last,
    input logic              hmem_we
);

    AST_WBANK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        32'(wbank) < NUM_BANKS); // R7

    AST_ACTIVE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        32'(active_bank) < NUM_BANKS); // R7

    AST_PENDING_KEEPS_ON_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_RBANK && reg_wdata >= 32'(NUM_BANKS))
            |=> $stable(pending_bank)); // R7

    AST_ACTIVE_HOLDS_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !sof |=> $stable(active_bank)); // R5

    AST_SWAP_TAKES_OLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (active_bank == $past(pending_bank))); // R6

    AST_COMMIT_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        h_last |=> hmem_we); // R9

    AST_COMMIT_NEEDS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        hmem_we |-> $past(h_last)); // R9

endmodule

bind coef_store coef_store_chk #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sof          (sof),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .wbank        (wbank),
    .pending_bank (pending_bank),
    .active_bank  (active_bank),
    .h_last       (h_last),
    .hmem_we      (hmem_we)
);

// File: tb/coef_store_tb.sv
`timescale 1ns/1ps
module coef_store_tb;

    localparam int PH = 4;
    localparam int VT = 3;
    localparam int HT = 4;
    localparam int CW = 10;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    logic        a_wr, b_wr, a_sof, b_sof;
    logic [1:0]  a_addr, b_addr;
    logic [31:0] a_wd, b_wd;
    logic [1:0]  a_vph, a_vtap, a_hph, b_vph, b_vtap, b_hph;
    logic [CW-1:0]    a_vcoef, b_vcoef;
    logic [CW*HT-1:0] a_hcoefs, b_hcoefs;

    coef_store #(
        .NUM_BANKS(2), .V_PHASES(PH), .V_TAPS(VT), .H_PHASES(PH),
        .H_TAPS(HT), .COEF_W(CW), .SHARE(1'b0)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(a_wr), .reg_addr(a_addr),
        .reg_wdata(a_wd), .sof(a_sof), .v_phase(a_vph), .v_tap(a_vtap),
        .h_phase(a_hph), .v_coef(a_vcoef), .h_coefs(a_hcoefs)
    );

    coef_store #(
        .NUM_BANKS(1), .V_PHASES(PH), .V_TAPS(VT), .H_PHASES(PH),
        .H_TAPS(HT), .COEF_W(CW), .SHARE(1'b1)
    ) u_dut_shared (
        .clk(clk), .rst_n(rst_n), .reg_wr(b_wr), .reg_addr(b_addr),
        .reg_wdata(b_wd), .sof(b_sof), .v_phase(b_vph), .v_tap(b_vtap),
        .h_phase(b_hph), .v_coef(b_vcoef), .h_coefs(b_hcoefs)
    );

    function automatic int cv(input int bank, input int horiz, input int ph,
                              input int tap, input int gen);
        return (bank * 211 + horiz * 97 + ph * 29 + tap * 7 + gen * 131 + 3) % 1024;
    endfunction

    function automatic logic [CW*HT-1:0] hword(input int bank, input int ph, input int gen);
        logic [CW*HT-1:0] w;
        for (int t = 0; t < HT; t++) begin
            w[t*CW +: CW] = CW'(cv(bank, 1, ph, t, gen));
        end
        return w;
    endfunction

    task automatic chk(input string req, input logic [CW*HT-1:0] act,
                       input logic [CW*HT-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input bit sel, input logic [1:0] addr, input logic [31:0] d);
        @(negedge clk);
        if (sel) begin b_wr = 1'b1; b_addr = addr; b_wd = d; end
        else     begin a_wr = 1'b1; a_addr = addr; a_wd = d; end
        @(negedge clk);
        a_wr = 1'b0;
        b_wr = 1'b0;
    endtask

    task automatic load(input bit sel, input bit horiz, input int ph, input int tap,
                        input int val);
        wr(sel, 2'd2, {15'd0, horiz, 8'(ph), 8'(tap)});
        wr(sel, 2'd3, 32'(val));
    endtask

    task automatic pulse_sof(input bit sel);
        @(negedge clk);
        if (sel) b_sof = 1'b1; else a_sof = 1'b1;
        @(negedge clk);
        a_sof = 1'b0;
        b_sof = 1'b0;
    endtask

    task automatic rd(input bit sel, input int vph, input int vtap, input int hph);
        @(negedge clk);
        if (sel) begin b_vph = 2'(vph); b_vtap = 2'(vtap); b_hph = 2'(hph); end
        else     begin a_vph = 2'(vph); a_vtap = 2'(vtap); a_hph = 2'(hph); end
        @(negedge clk);
    endtask

    task automatic load_bank_a(input int bank);
        wr(1'b0, 2'd0, 32'(bank));
        for (int ph = 0; ph < PH; ph++) begin
            for (int t = 0; t < VT; t++) load(1'b0, 1'b0, ph, t, cv(bank, 0, ph, t, 0));
            for (int t = 0; t < HT; t++) load(1'b0, 1'b1, ph, t, cv(bank, 1, ph, t, 0));
        end
    endtask

    task automatic sweep_a(input int bank, input string tag);
        for (int ph = 0; ph < PH; ph++) begin
            for (int t = 0; t < VT; t++) begin
                rd(1'b0, ph, t, ph);
                chk({tag, " R2 vertical lookup"}, (CW*HT)'(a_vcoef),
                    (CW*HT)'(cv(bank, 0, ph, t, 0)));
                if (t == 0) chk({tag, " R3 horizontal lookup"}, a_hcoefs, hword(bank, ph, 0));
            end
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        a_wr = 0; b_wr = 0; a_sof = 0; b_sof = 0;
        a_addr = 0; b_addr = 0; a_wd = 0; b_wd = 0;
        a_vph = 0; a_vtap = 0; a_hph = 0; b_vph = 0; b_vtap = 0; b_hph = 0;
        repeat (3) @(negedge clk);
        // R1: outputs held at zero in reset
        chk("R1 vertical out in reset", (CW*HT)'(a_vcoef), '0);
        chk("R1 horizontal out in reset", a_hcoefs, '0);
        chk("R1 shared vertical out in reset", (CW*HT)'(b_vcoef), '0);
        rst_n = 1'b1;

        // R4: fill both banks through the register window
        load_bank_a(0);
        load_bank_a(1);
        sweep_a(0, "bank0 after reset");

        // R5: pending bank does not act before sof
        wr(1'b0, 2'd1, 32'd1);
        rd(1'b0, 2, 1, 2);
        chk("R5 no swap before sof", (CW*HT)'(a_vcoef), (CW*HT)'(cv(0, 0, 2, 1, 0)));
        pulse_sof(1'b0);
        sweep_a(1, "R5 after sof");

        // R7: illegal bank values are ignored
        wr(1'b0, 2'd1, 32'd2);
        wr(1'b0, 2'd1, 32'd3);
        pulse_sof(1'b0);
        rd(1'b0, 0, 2, 1);
        chk("R7 illegal read bank ignored", (CW*HT)'(a_vcoef), (CW*HT)'(cv(1, 0, 0, 2, 0)));
        chk("R7 illegal read bank ignored h", a_hcoefs, hword(1, 1, 0));
        wr(1'b0, 2'd0, 32'd3);
        load(1'b0, 1'b0, 1, 1, cv(1, 0, 1, 1, 5));
        rd(1'b0, 1, 1, 0);
        chk("R7 R8 write after illegal write bank", (CW*HT)'(a_vcoef),
            (CW*HT)'(cv(1, 0, 1, 1, 5)));

        // R8: vertical tap beyond V_TAPS is dropped (would alias phase 2 tap 0)
        load(1'b0, 1'b0, 1, 3, 777);
        rd(1'b0, 2, 0, 0);
        chk("R8 out-of-range tap ignored", (CW*HT)'(a_vcoef), (CW*HT)'(cv(1, 0, 2, 0, 0)));

        // R9: partial horizontal load leaves memory untouched
        for (int t = 0; t < HT - 1; t++) load(1'b0, 1'b1, 2, t, cv(1, 1, 2, t, 6));
        rd(1'b0, 0, 0, 2);
        chk("R9 no commit before last tap", a_hcoefs, hword(1, 2, 0));
        load(1'b0, 1'b1, 2, HT - 1, cv(1, 1, 2, HT - 1, 6));
        rd(1'b0, 0, 0, 2);
        chk("R9 commit on last tap", a_hcoefs, hword(1, 2, 6));

        // R6: sof and pending write on the same edge
        @(negedge clk);
        a_wr = 1'b1; a_addr = 2'd1; a_wd = 32'd0; a_sof = 1'b1;
        @(negedge clk);
        a_wr = 1'b0; a_sof = 1'b0;
        rd(1'b0, 0, 0, 0);
        chk("R6 swap used old pending", (CW*HT)'(a_vcoef), (CW*HT)'(cv(1, 0, 0, 0, 0)));
        // R5: lookup on the swap edge sees the old bank
        @(negedge clk);
        a_sof = 1'b1; a_vph = 2'd0; a_vtap = 2'd0; a_hph = 2'd2;
        @(negedge clk);
        a_sof = 1'b0;
        chk("R5 lookup on swap edge", (CW*HT)'(a_vcoef), (CW*HT)'(cv(1, 0, 0, 0, 0)));
        chk("R5 lookup on swap edge h", a_hcoefs, hword(1, 2, 6));
        rd(1'b0, 0, 0, 0);
        chk("R6 new pending after next sof", (CW*HT)'(a_vcoef), (CW*HT)'(cv(0, 0, 0, 0, 0)));
        rd(1'b0, 1, 1, 2);
        chk("R7 bank0 untouched by stray write", (CW*HT)'(a_vcoef),
            (CW*HT)'(cv(0, 0, 1, 1, 0)));
        chk("R9 commit landed in write bank only", a_hcoefs, hword(0, 2, 0));

        // shared, single-bank instance
        wr(1'b1, 2'd0, 32'd1);
        for (int ph = 0; ph < PH; ph++)
            for (int t = 0; t < HT; t++) load(1'b1, 1'b1, ph, t, cv(0, 1, ph, t, 2));
        for (int ph = 0; ph < PH; ph++) begin
            for (int t = 0; t < VT; t++) begin
                rd(1'b1, ph, t, ph);
                chk("R11 vertical from horizontal word", (CW*HT)'(b_vcoef),
                    (CW*HT)'(cv(0, 1, ph, t, 2)));
            end
            chk("R3 R7 shared horizontal lookup", b_hcoefs, hword(0, ph, 2));
        end
        load(1'b1, 1'b0, 0, 0, 5);
        rd(1'b1, 0, 0, 0);
        chk("R11 vertical write ignored", (CW*HT)'(b_vcoef), (CW*HT)'(cv(0, 1, 0, 0, 2)));
        for (int t = 0; t < HT; t++) load(1'b1, 1'b1, 3, t, cv(0, 1, 3, t, 4));
        rd(1'b1, 3, 2, 3);
        chk("R10 single bank write immediate", (CW*HT)'(b_vcoef), (CW*HT)'(cv(0, 1, 3, 2, 4)));
        chk("R10 single bank write immediate h", b_hcoefs, hword(0, 3, 4));
        wr(1'b1, 2'd1, 32'd1);
        pulse_sof(1'b1);
        rd(1'b1, 3, 2, 3);
        chk("R7 single bank illegal read bank", (CW*HT)'(b_vcoef), (CW*HT)'(cv(0, 1, 3, 2, 4)));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule